// File: doc/BRIEF.md
# Multi-Link Event Buffer

This block gathers the per-event contributions of twelve link receivers and assembles them into whole events in a shared event memory. Each link writes its words, in the link clock domain, into a dual-clock FIFO of its own. In the faster core clock domain, a round-robin scheduler moves words from the FIFOs into the event memory. A link stays in the running only until its end marker for the current event has been taken.

Every event owns one of a fixed number of memory slots. Inside a slot, each link has a block base, and a running offset advances from that base as the link's words arrive. An event is complete once every link has delivered its end marker. Completed events go, oldest first, to a 32-bit output stream: a generated header word, then the event's data. A downstream full signal can hold that stream back.

When a new event begins and every slot is still occupied, the whole event is discarded and a drop counter is incremented. The slot of a shipped event is released when its final word is accepted.

Top module: `evb_event_buffer`

## Requirements
- R1: After reset, `out_valid` is 0, `buf_full` is 0 and `drop_cnt` is 0.
- R2: An event is committed only after every one of the NL links has delivered a word with its end flag set. Each link's end flag travels with that link's last data word. While any link's end marker is missing, no part of the event is shipped.
- R3: Each link has its own FIFO of FIFO_DEPTH entries. A link presents at most FIFO_DEPTH words before the scheduler has drained them, and no word is lost or reordered in transit.
- R4: Each shipped event starts with a header word. Bits [31:16] carry the sequence number of the kept event, counting 0, 1, 2 and so on, with dropped events skipped. Bits [15:0] carry the number of 32-bit data words that follow.
- R5: After the header, links come in ascending index order. Within a link, words come in arrival order, and each 128-bit word is sent as four 32-bit words, bits [31:0] first and bits [127:96] last.
- R6: A link word beyond MAXW in one event is discarded, and the event keeps only the first MAXW words of that link.
- R7: `out_last` is 1 exactly on the final data word of each event.
- R8: A word moves on a `clk_core` edge where `out_valid` is 1 and `link_full` is 0. While `out_valid` is 1 and `link_full` is 1, `out_data` and `out_last` hold their values.
- R9: Up to NSLOT complete events are held at once. `buf_full` is 1 exactly while NSLOT events are held.
- R10: An event whose first word is taken while `buf_full` is 1 is dropped as a whole. It writes no data, `drop_cnt` is incremented by one, and no sequence number is used.
- R11: Events are shipped in commit order. A slot is freed on the edge that accepts the event's last word, and `buf_full` falls only on such an edge.
- R12: The scheduler grants at most one link per cycle. It serves only links that have a non-empty FIFO and no end marker yet for the current event, rotating past the last grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lnk | input | 1 | Link-side clock |
| rst_lnk | input | 1 | Synchronous active-high reset, link side |
| lnk_valid | input | NL | Per-link word strobe |
| lnk_end | input | NL | Per-link end flag, set with the link's last word of an event |
| lnk_data | input | NL*DW | Per-link data words, link i at bits [i*DW +: DW] |
| clk_core | input | 1 | Core clock for assembly and read-out |
| rst_core | input | 1 | Synchronous active-high reset, core side |
| link_full | input | 1 | Downstream back-pressure |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Header or data word |
| out_last | output | 1 | Final word of an event |
| buf_full | output | 1 | All event slots occupied |
| drop_cnt | output | CNT_W | Number of dropped events |

## Verification
Two things can fall on the same core edge: the commit of a newly completed event, which raises the held count, and the acceptance of the last word of the oldest event, which lowers it. The bench provokes this by sending one-word-per-link events at a sweep of spacings close to the read-out time of one event, while back-pressure pulses every seventh cycle. The result is judged by checking that every sent event comes out whole, in order and with consecutive sequence numbers, that nothing is dropped, and that `buf_full` is low at the end. Separately, a full buffer is held under back-pressure while a single event and then an overlapping pair arrive, to check whole-event drops against the counter.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int OUT_W = 32;
  typedef enum logic [2:0] {
    RO_IDLE, RO_HDR, RO_FETCH, RO_WAIT, RO_SEND, RO_TAIL
  } ro_state_t;
endpackage

// File: rtl/evb_link_fifo.sv
module evb_link_fifo #(
  parameter int DW = 129,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wfull,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rempty
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] store [DEPTH];
  logic [AW:0] wbin, wgray, wnext, rbin, rgray, rnext;
  logic [AW:0] rg_s1, rg_s2, wg_s1, wg_s2;

  assign wnext = wbin + 1'b1;
  assign rnext = rbin + 1'b1;
  assign wfull  = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
  assign rempty = (rgray == wg_s2);
  assign rdata  = store[rbin[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (wen && !wfull) store[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wen && !wfull) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (ren && !rempty) begin
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
    end
  end
endmodule

// File: rtl/evb_rr_arb.sv
module evb_rr_arb #(
  parameter int N  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] last;

  always_comb begin
    gnt = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last) + k) % N;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt[c] = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= IW'(N - 1);
    else if (gnt_any) last <= gnt_idx;
  end
endmodule

// File: rtl/evb_readout.sv
module evb_readout
  import evb_pkg::*;
#(
  parameter int NL     = 12,
  parameter int MAXW   = 4,
  parameter int DW     = 128,
  parameter int ADDR_W = 18,
  parameter int LW     = $clog2(MAXW + 1),
  parameter int IW     = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              avail,
  input  logic [NL*LW-1:0]  lens,
  input  logic [ADDR_W-1:0] slot_base,
  input  logic [DW-1:0]     mem_q,
  input  logic              link_full,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_last,
  output logic              done
);
  localparam int SUBS = DW / OUT_W;
  localparam int SBW  = $clog2(SUBS);

  ro_state_t     state;
  logic [IW-1:0] lnk;
  logic [LW-1:0] wix, len_cur;
  logic [SBW-1:0] sub;
  logic [15:0]   seq, total;
  logic          ld, last_word, link_last;

  assign len_cur   = lens[int'(lnk)*LW +: LW];
  assign link_last = (int'(wix) + 1 >= int'(len_cur));
  assign last_word = (int'(lnk) == NL - 1) && link_last;
  assign ld        = !out_valid || !link_full;
  assign done      = (state == RO_TAIL) && !link_full;

  always_comb begin
    total = '0;
    for (int i = 0; i < NL; i++) total = total + 16'(lens[i*LW +: LW]);
    total = total * 16'(SUBS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RO_IDLE; out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
      lnk <= '0; wix <= '0; sub <= '0; seq <= '0; mem_raddr <= '0;
    end else begin
      if (ld) out_valid <= 1'b0;
      case (state)
        RO_IDLE: if (avail) state <= RO_HDR;
        RO_HDR: if (ld) begin
          out_valid <= 1'b1; out_data <= {seq, total}; out_last <= 1'b0;
          lnk <= '0; wix <= '0; state <= RO_FETCH;
        end
        RO_FETCH: begin
          mem_raddr <= slot_base + ADDR_W'(int'(lnk) * MAXW) + ADDR_W'(wix);
          sub <= '0; state <= RO_WAIT;
        end
        RO_WAIT: state <= RO_SEND;
        RO_SEND: if (ld) begin
          out_valid <= 1'b1;
          out_data  <= mem_q[int'(sub)*OUT_W +: OUT_W];
          out_last  <= (int'(sub) == SUBS - 1) && last_word;
          sub <= sub + 1'b1;
          if (int'(sub) == SUBS - 1) begin
            if (last_word) state <= RO_TAIL;
            else begin
              state <= RO_FETCH;
              if (link_last) begin lnk <= lnk + 1'b1; wix <= '0; end
              else wix <= wix + 1'b1;
            end
          end
        end
        RO_TAIL: if (!link_full) begin state <= RO_IDLE; seq <= seq + 1'b1; end
        default: state <= RO_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evb_event_buffer.sv
module evb_event_buffer
  import evb_pkg::*;
#(
  parameter int NL     = 12,
  parameter int DW     = 128,
  parameter int MAXW   = 4,
  parameter int NSLOT  = 4,
  parameter int FAW    = 3,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic             clk_lnk,
  input  logic             rst_lnk,
  input  logic [NL-1:0]    lnk_valid,
  input  logic [NL-1:0]    lnk_end,
  input  logic [NL*DW-1:0] lnk_data,
  input  logic             clk_core,
  input  logic             rst_core,
  input  logic             link_full,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last,
  output logic             buf_full,
  output logic [CNT_W-1:0] drop_cnt
);
  localparam int LW        = $clog2(MAXW + 1);
  localparam int IW        = $clog2(NL);
  localparam int EVW       = NL * MAXW;
  localparam int MEM_DEPTH = NSLOT * EVW;
  localparam int MAW       = $clog2(MEM_DEPTH);
  localparam int SW        = $clog2(NSLOT);
  localparam int UW        = $clog2(NSLOT + 1);

  logic [NL-1:0] f_full, f_empty, seen_end, elig, gnt;
  logic [DW:0]   f_rdata [NL];
  logic [IW-1:0] gnt_idx;
  logic          gnt_any;
  logic [LW-1:0] off [NL];
  logic [LW-1:0] len_mem [NSLOT][NL];
  logic [NL*LW-1:0] lens_rd;
  logic [SW-1:0] wr_slot, rd_slot;
  logic [UW-1:0] used, used_nx;
  logic          in_evt, dropping, start, drop_now, evt_done, commit, done, we;
  logic [DW:0]   pop_word;
  logic [LW-1:0] cur_off;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DW-1:0] ev_mem [MEM_DEPTH];
  logic [DW-1:0] mem_q;

  function automatic logic [ADDR_W-1:0] slot_base(input logic [SW-1:0] s);
    return ADDR_W'(int'(s) * EVW);
  endfunction

  for (genvar i = 0; i < NL; i++) begin : g_fifo
    evb_link_fifo #(.DW(DW + 1), .AW(FAW)) u_fifo (
      .wclk(clk_lnk), .wrst(rst_lnk), .wen(lnk_valid[i]),
      .wdata({lnk_end[i], lnk_data[i*DW +: DW]}), .wfull(f_full[i]),
      .rclk(clk_core), .rrst(rst_core), .ren(gnt[i]),
      .rdata(f_rdata[i]), .rempty(f_empty[i]));
  end

  assign elig = ~f_empty & ~seen_end;

  evb_rr_arb #(.N(NL), .IW(IW)) u_arb (
    .clk(clk_core), .rst(rst_core), .req(elig),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any));

  assign pop_word = f_rdata[gnt_idx];
  assign cur_off  = off[gnt_idx];
  assign evt_done = &seen_end;
  assign start    = gnt_any && !in_evt;
  assign drop_now = start ? buf_full : dropping;
  assign we       = gnt_any && !drop_now && (int'(cur_off) < MAXW);
  assign waddr    = slot_base(wr_slot) + ADDR_W'(int'(gnt_idx) * MAXW) + ADDR_W'(cur_off);
  assign commit   = evt_done && !dropping;
  assign used_nx  = used + UW'(commit) - UW'(done);

  always_comb begin
    for (int l = 0; l < NL; l++) lens_rd[l*LW +: LW] = len_mem[rd_slot][l];
  end

  always_ff @(posedge clk_core) begin
    if (we) ev_mem[waddr[MAW-1:0]] <= pop_word[DW-1:0];
    mem_q <= ev_mem[raddr[MAW-1:0]];
  end

  always_ff @(posedge clk_core) begin
    if (rst_core) begin
      in_evt <= 1'b0; dropping <= 1'b0; seen_end <= '0;
      wr_slot <= '0; rd_slot <= '0; used <= '0; buf_full <= 1'b0; drop_cnt <= '0;
      for (int l = 0; l < NL; l++) off[l] <= '0;
    end else begin
      if (evt_done) begin
        seen_end <= '0; in_evt <= 1'b0; dropping <= 1'b0;
        for (int l = 0; l < NL; l++) off[l] <= '0;
        if (!dropping) begin
          for (int l = 0; l < NL; l++) len_mem[wr_slot][l] <= off[l];
          wr_slot <= (int'(wr_slot) == NSLOT - 1) ? '0 : wr_slot + 1'b1;
        end
      end else if (gnt_any) begin
        if (start) begin
          in_evt <= 1'b1;
          dropping <= buf_full;
          if (buf_full) drop_cnt <= drop_cnt + 1'b1;
        end
        if (pop_word[DW]) seen_end[gnt_idx] <= 1'b1;
        if (we) off[gnt_idx] <= cur_off + 1'b1;
      end
      if (done) rd_slot <= (int'(rd_slot) == NSLOT - 1) ? '0 : rd_slot + 1'b1;
      used <= used_nx;
      buf_full <= (int'(used_nx) == NSLOT);
    end
  end

  evb_readout #(.NL(NL), .MAXW(MAXW), .DW(DW), .ADDR_W(ADDR_W), .LW(LW), .IW(IW)) u_ro (
    .clk(clk_core), .rst(rst_core), .avail(used != '0), .lens(lens_rd),
    .slot_base(slot_base(rd_slot)), .mem_q(mem_q), .link_full(link_full),
    .mem_raddr(raddr), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .done(done));
endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
  parameter int NL    = 12,
  parameter int CNT_W = 16
) (
  input logic             clk_lnk,
  input logic             rst_lnk,
  input logic             clk_core,
  input logic             rst_core,
  input logic [NL-1:0]    lnk_valid,
  input logic [NL-1:0]    f_full,
  input logic [NL-1:0]    gnt,
  input logic [NL-1:0]    elig,
  input logic             out_valid,
  input logic [31:0]      out_data,
  input logic             out_last,
  input logic             link_full,
  input logic             buf_full,
  input logic [CNT_W-1:0] drop_cnt
);
  assert_no_overflow_R3: assert property (@(posedge clk_lnk) disable iff (rst_lnk)
    (lnk_valid & f_full) == '0);

  assert_grant_legal_R12: assert property (@(posedge clk_core) disable iff (rst_core)
    $onehot0(gnt) && ((gnt & ~elig) == '0));

  assert_hold_R8: assert property (@(posedge clk_core) disable iff (rst_core)
    (out_valid && link_full) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_drop_when_full_R10: assert property (@(posedge clk_core) disable iff (rst_core)
    (drop_cnt != $past(drop_cnt)) |-> ($past(buf_full) && drop_cnt == $past(drop_cnt) + 1'b1));

  assert_free_on_last_R11: assert property (@(posedge clk_core) disable iff (rst_core)
    $fell(buf_full) |-> $past(out_valid && out_last && !link_full));
endmodule

bind evb_event_buffer evb_checker #(.NL(NL), .CNT_W(CNT_W)) u_chk (
  .clk_lnk(clk_lnk), .rst_lnk(rst_lnk), .clk_core(clk_core), .rst_core(rst_core),
  .lnk_valid(lnk_valid), .f_full(f_full), .gnt(gnt), .elig(elig),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
  .link_full(link_full), .buf_full(buf_full), .drop_cnt(drop_cnt));

// File: tb/tb_evb_event_buffer.sv
`timescale 1ns/1ps
module tb_evb_event_buffer;
  localparam int NL = 12, DW = 128, MAXW = 4, NSLOT = 4;
  localparam int EXTRA_E = 6, SMALL_E0 = 22;

  logic clk_lnk = 0, clk_core = 0, rst_lnk = 1, rst_core = 1;
  logic [NL-1:0] lnk_valid = '0, lnk_end = '0;
  logic [NL*DW-1:0] lnk_data = '0;
  logic link_full = 0;
  logic out_valid, out_last, buf_full;
  logic [31:0] out_data;
  logic [15:0] drop_cnt;

  always #4   clk_lnk  = ~clk_lnk;
  always #2.5 clk_core = ~clk_core;

  evb_event_buffer dut (
    .clk_lnk(clk_lnk), .rst_lnk(rst_lnk), .lnk_valid(lnk_valid), .lnk_end(lnk_end),
    .lnk_data(lnk_data), .clk_core(clk_core), .rst_core(rst_core), .link_full(link_full),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .buf_full(buf_full), .drop_cnt(drop_cnt));

  int n_chk = 0, n_bad = 0, seq_nx = 0, lf_mode = 0, cyc = 0;
  logic [31:0] exp_q[$];
  logic        exp_last[$];
  string       exp_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk_core) begin
    #1;
    cyc++;
    link_full = (lf_mode == 1) ? 1'b1 : (lf_mode == 2) ? (cyc % 7 == 0) : 1'b0;
  end

  function automatic int sent_len(int e, int i);
    if (e == EXTRA_E && i == 2) return MAXW + 1;
    if (e >= SMALL_E0) return 1;
    return ((e * 5 + i * 3) % MAXW) + 1;
  endfunction

  function automatic int kept_len(int e, int i);
    return (sent_len(e, i) > MAXW) ? MAXW : sent_len(e, i);
  endfunction

  function automatic logic [31:0] piece(int e, int i, int k, int s);
    return {8'(e), 8'(i), 8'(k), 8'(s)};
  endfunction

  task automatic push_exp(input int e, input string tag);
    int total = 0;
    for (int i = 0; i < NL; i++) total += kept_len(e, i);
    exp_q.push_back({16'(seq_nx), 16'(4 * total)});
    exp_last.push_back(1'b0);
    exp_tag.push_back("R4 header");
    for (int i = 0; i < NL; i++)
      for (int k = 0; k < kept_len(e, i); k++)
        for (int s = 0; s < 4; s++) begin
          exp_q.push_back(piece(e, i, k, s));
          exp_last.push_back(i == NL - 1 && k == kept_len(e, i) - 1 && s == 3);
          exp_tag.push_back(tag);
        end
    seq_nx++;
  endtask

  task automatic send_events(input int e0, input int n, input int lo, input int hi);
    int ev[NL];
    int kk[NL];
    bit busy = 1;
    for (int i = 0; i < NL; i++) begin ev[i] = e0; kk[i] = 0; end
    while (busy) begin
      @(negedge clk_lnk);
      busy = 0;
      for (int i = 0; i < NL; i++) begin
        if (i >= lo && i <= hi && ev[i] < e0 + n) begin
          busy = 1;
          lnk_valid[i] = 1'b1;
          lnk_end[i]   = (kk[i] == sent_len(ev[i], i) - 1);
          lnk_data[i*DW +: DW] = {piece(ev[i], i, kk[i], 3), piece(ev[i], i, kk[i], 2),
                                  piece(ev[i], i, kk[i], 1), piece(ev[i], i, kk[i], 0)};
          kk[i]++;
          if (kk[i] == sent_len(ev[i], i)) begin ev[i]++; kk[i] = 0; end
        end else begin
          lnk_valid[i] = 1'b0;
          lnk_end[i]   = 1'b0;
        end
      end
    end
  endtask

  task automatic wait_core(input int n);
    repeat (n) @(negedge clk_core);
  endtask

  task automatic wait_drain();
    int t = 0;
    while (exp_q.size() > 0 && t < 20000) begin @(negedge clk_core); t++; end
    chk(exp_q.size() == 0, "R11 all held events shipped", 64'(exp_q.size()), 0);
  endtask

  // Transfer monitor: R4, R5, R6, R7, R11 and friends
  always @(negedge clk_core) begin
    if (!rst_core && out_valid && !link_full) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected word", 64'(out_data), 0);
      end else begin
        chk(out_data == exp_q[0], exp_tag[0], 64'(out_data), 64'(exp_q[0]));
        chk(out_last == exp_last[0], "R7 last flag", 64'(out_last), 64'(exp_last[0]));
        void'(exp_q.pop_front());
        void'(exp_last.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk_core);
    chk(1'b0, "watchdog expired", 0, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (6) @(posedge clk_lnk);
    @(negedge clk_lnk) rst_lnk = 0;
    @(negedge clk_core) rst_core = 0;
    wait_core(4);
    chk(out_valid == 0, "R1 out_valid after reset", 64'(out_valid), 0);
    chk(buf_full == 0, "R1 buf_full after reset", 64'(buf_full), 0);
    chk(drop_cnt == 0, "R1 drop_cnt after reset", 64'(drop_cnt), 0);

    // length sweep, single events
    for (int e = 0; e < 6; e++) begin
      push_exp(e, "R5 data order");
      send_events(e, 1, 0, NL - 1);
      wait_drain();
    end
    // over-long link contribution
    push_exp(EXTRA_E, "R6 truncation");
    send_events(EXTRA_E, 1, 0, NL - 1);
    wait_drain();
    // overlapping pairs: next event words queued behind end markers
    for (int e = 7; e < 13; e += 2) begin
      push_exp(e, "R12 scheduler separation");
      push_exp(e + 1, "R3 fifo path");
      send_events(e, 2, 0, NL - 1);
      wait_drain();
    end
    // incomplete event must not ship
    push_exp(13, "R2 completion");
    send_events(13, 1, 0, NL - 2);
    wait_core(100);
    chk(out_valid == 0, "R2 no output before last end marker", 64'(out_valid), 0);
    send_events(13, 1, NL - 1, NL - 1);
    wait_drain();
    chk(drop_cnt == 0, "R10 no drops so far", 64'(drop_cnt), 0);

    // fill all slots under back-pressure
    lf_mode = 1;
    wait_core(3);
    for (int e = 14; e < 18; e++) begin
      push_exp(e, "R9 held event");
      send_events(e, 1, 0, NL - 1);
      wait_core(150);
      if (e < 17) chk(buf_full == 0, "R9 buf_full below capacity", 64'(buf_full), 0);
    end
    chk(buf_full == 1, "R9 buf_full at capacity", 64'(buf_full), 1);
    chk(out_valid == 1, "R8 header presented", 64'(out_valid), 1);
    chk(out_data == exp_q[0], "R4 first held header", 64'(out_data), 64'(exp_q[0]));
    held = out_data;
    wait_core(20);
    chk(out_data == held && out_valid, "R8 held under link_full", 64'(out_data), 64'(held));
    send_events(18, 1, 0, NL - 1);
    wait_core(150);
    chk(drop_cnt == 1, "R10 single drop", 64'(drop_cnt), 1);
    chk(buf_full == 1, "R10 still full after drop", 64'(buf_full), 1);
    send_events(19, 2, 0, NL - 1);
    wait_core(250);
    chk(drop_cnt == 3, "R10 pair dropped", 64'(drop_cnt), 3);
    lf_mode = 0;
    wait_drain();
    wait_core(5);
    chk(buf_full == 0, "R11 slots freed", 64'(buf_full), 0);
    push_exp(21, "R10 sequence continues");
    send_events(21, 1, 0, NL - 1);
    wait_drain();

    // commit and free on nearby edges
    lf_mode = 2;
    for (int j = 0; j < 21; j++) begin
      push_exp(SMALL_E0 + j, "R11 commit/free overlap");
      send_events(SMALL_E0 + j, 1, 0, NL - 1);
      wait_core(70 + 2 * j);
    end
    wait_drain();
    lf_mode = 0;
    wait_core(5);
    chk(drop_cnt == 3, "R10 no drop in overlap sweep", 64'(drop_cnt), 3);
    chk(buf_full == 0, "R9 empty at end", 64'(buf_full), 0);

    summary();
    $finish;
  end
endmodule